// File: doc/BRIEF.md
# Masked Parallel Pad Output Bank

The block holds the output data bits for a bank of general-purpose pads, organised as a number of 16-pin ports (twelve by default, 192 pads in all). Software can change these bits in two ways, and both act on the same storage. The first is a masked port register, one per port. A single 32-bit write carries a 16-bit enable mask in its upper half and 16 data bits in its lower half. Only the pads whose mask bit is set take the new data, so several pins of one port change in one bus cycle without a read-modify-write. The second is a per-pad register, one byte address per pad, that sets or clears a single pin.

Two identical register-bus ports (A and B) reach the bank. Each has an address, a write enable, write data and read data. This lets two masters, or one master and a hardware agent, update pins in the same cycle under a fixed priority. In each port word, the most significant data bit drives the lowest-numbered pin of that port. The stored bits appear on a flat registered vector of pad output values.

Top module: `gpio_mpo_bank`

## Requirements
- R1: While `rst` is high at a clock edge, every stored bit is cleared. After reset, `pad_out` and both read data outputs are all zero.
- R2: A write to masked port register x updates pad 16x+y only where the mask bit for y is 1; pads whose mask bit is 0 keep their value. The mask bit for y is `wdata[31-y]` and the data bit is `wdata[15-y]`.
- R3: The port word is bit-reversed against the pins. `wdata[15]` goes to pad 16x, the lowest pin of the port, and `wdata[0]` goes to pad 16x+15, the highest.
- R4: Masked port register x sits at byte address PAR_BASE+4x, for x from 0 to NUM_PORTS-1. A read of any of these addresses returns 0.
- R5: Per-pad register n sits at byte address PAD_BASE+n, for n from 0 to 191. A write stores `wdata[0]` into pad n and ignores the other data bits. A read returns the pad value in bit 0 and zero in bits 31:1.
- R6: The two views share one storage array. A write through either view is visible on `pad_out`, and through a per-pad read, from the first cycle after the write edge. `rdata` is registered: it reflects the storage as it stood at the edge where the address was sampled.
- R7: If a masked port write and a per-pad write change the same pad at the same edge, the masked port write decides the value, whichever bus port carries it.
- R8: If both bus ports write the same pad through the same kind of register at the same edge, bus port A decides the value.
- R9: A write to an address outside both ranges, or to an address in the port range that is not word-aligned, changes nothing. A read of such an address returns 0.
- R10: Bus port B has the same map and behaviour as bus port A, apart from its lower priority under R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_addr | input | 12 | Bus port A byte address |
| a_we | input | 1 | Bus port A write enable |
| a_wdata | input | 32 | Bus port A write data |
| a_rdata | output | 32 | Bus port A read data, one cycle after the address |
| b_addr | input | 12 | Bus port B byte address |
| b_we | input | 1 | Bus port B write enable |
| b_wdata | input | 32 | Bus port B write data |
| b_rdata | output | 32 | Bus port B read data, one cycle after the address |
| pad_out | output | 192 | Registered pad output values, pad n on bit n |

## Verification
All stored state is visible on `pad_out` at every clock. A wrong mask bit, a reversed or shifted port mapping, or a lost priority therefore shows on the pad vector in the cycle right after the faulty write edge. The bench compares the whole vector against a reference model after every cycle. This includes random masked and per-pad writes on both bus ports, same-edge collisions and the first and last pin of every port. A decode fault in the read path shows one cycle after the address as a nonzero word from a masked port address or from an address outside both ranges, or as a per-pad read that disagrees with the pad vector.

// File: rtl/gpio_mpo_pkg.sv
package gpio_mpo_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_PAR  = 2'd1,
    ACC_PAD  = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/mpo_decode.sv
// Decodes one bus port into per-pad write strobes for both views.
module mpo_decode
  import gpio_mpo_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 12,
  parameter int unsigned PORT_W    = 16,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned PAR_BASE  = 0,
  parameter int unsigned PAD_BASE  = 256,
  localparam int unsigned NPADS    = NUM_PORTS * PORT_W,
  localparam int unsigned BUS_W    = 2 * PORT_W,
  localparam int unsigned IDX_W    = $clog2(NPADS)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [BUS_W-1:0]  wdata,
  output logic [NPADS-1:0]  par_en,
  output logic [NPADS-1:0]  par_val,
  output logic [NPADS-1:0]  pad_en,
  output logic [NPADS-1:0]  pad_val,
  output acc_kind_e         kind,
  output logic [IDX_W-1:0]  pad_idx
);
  localparam int unsigned PAR_SPAN = NUM_PORTS * 4;

  logic [ADDR_W-1:0] par_off, pad_off;
  logic              in_par, in_pad;

  assign par_off = addr - ADDR_W'(PAR_BASE);
  assign pad_off = addr - ADDR_W'(PAD_BASE);
  assign in_par  = (addr >= ADDR_W'(PAR_BASE)) && (par_off < ADDR_W'(PAR_SPAN))
                   && (par_off[1:0] == 2'b00);
  assign in_pad  = (addr >= ADDR_W'(PAD_BASE)) && (pad_off < ADDR_W'(NPADS));

  always_comb begin
    if (in_pad)      kind = ACC_PAD;
    else if (in_par) kind = ACC_PAR;
    else             kind = ACC_NONE;
  end
  assign pad_idx = pad_off[IDX_W-1:0];

  for (genvar x = 0; x < NUM_PORTS; x++) begin : g_port
    logic port_hit;
    assign port_hit = we && in_par && (par_off[ADDR_W-1:2] == (ADDR_W-2)'(x));
    for (genvar y = 0; y < PORT_W; y++) begin : g_bit
      localparam int unsigned N = x * PORT_W + y;
      // most significant data bit drives the lowest pin of the port
      assign par_en[N]  = port_hit && wdata[BUS_W-1-y];
      assign par_val[N] = wdata[PORT_W-1-y];
      assign pad_en[N]  = we && in_pad && (pad_off == ADDR_W'(N));
      assign pad_val[N] = wdata[0];
    end
  end
endmodule

// File: rtl/mpo_store.sv
// Shared pad output storage with fixed write priority.
module mpo_store #(
  parameter int unsigned NPADS = 192
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPADS-1:0] a_par_en,
  input  logic [NPADS-1:0] a_par_val,
  input  logic [NPADS-1:0] a_pad_en,
  input  logic [NPADS-1:0] a_pad_val,
  input  logic [NPADS-1:0] b_par_en,
  input  logic [NPADS-1:0] b_par_val,
  input  logic [NPADS-1:0] b_pad_en,
  input  logic [NPADS-1:0] b_pad_val,
  output logic [NPADS-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      for (int n = 0; n < NPADS; n++) begin
        if (a_par_en[n])      q[n] <= a_par_val[n];
        else if (b_par_en[n]) q[n] <= b_par_val[n];
        else if (a_pad_en[n]) q[n] <= a_pad_val[n];
        else if (b_pad_en[n]) q[n] <= b_pad_val[n];
      end
    end
  end
endmodule

// File: rtl/mpo_rdport.sv
// Registered read path: per-pad view returns the bit, all else 0.
module mpo_rdport
  import gpio_mpo_pkg::*;
#(
  parameter int unsigned NPADS  = 192,
  parameter int unsigned BUS_W  = 32,
  localparam int unsigned IDX_W = $clog2(NPADS)
) (
  input  logic             clk,
  input  logic             rst,
  input  acc_kind_e        kind,
  input  logic [IDX_W-1:0] pad_idx,
  input  logic [NPADS-1:0] q,
  output logic [BUS_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst)                  rdata <= '0;
    else if (kind == ACC_PAD) rdata <= {{(BUS_W-1){1'b0}}, q[pad_idx]};
    else                      rdata <= '0;
  end
endmodule

// File: rtl/gpio_mpo_bank.sv
module gpio_mpo_bank
  import gpio_mpo_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 12,
  parameter int unsigned PORT_W    = 16,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned PAR_BASE  = 0,
  parameter int unsigned PAD_BASE  = 256,
  localparam int unsigned NPADS    = NUM_PORTS * PORT_W,
  localparam int unsigned BUS_W    = 2 * PORT_W,
  localparam int unsigned IDX_W    = $clog2(NPADS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_we,
  input  logic [BUS_W-1:0]  a_wdata,
  output logic [BUS_W-1:0]  a_rdata,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_we,
  input  logic [BUS_W-1:0]  b_wdata,
  output logic [BUS_W-1:0]  b_rdata,
  output logic [NPADS-1:0]  pad_out
);
  logic [NPADS-1:0] a_par_en, a_par_val, a_pad_en, a_pad_val;
  logic [NPADS-1:0] b_par_en, b_par_val, b_pad_en, b_pad_val;
  acc_kind_e        a_kind, b_kind;
  logic [IDX_W-1:0] a_idx, b_idx;
  logic [NPADS-1:0] q;

  mpo_decode #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .ADDR_W(ADDR_W),
               .PAR_BASE(PAR_BASE), .PAD_BASE(PAD_BASE)) u_dec_a (
    .addr(a_addr), .we(a_we), .wdata(a_wdata),
    .par_en(a_par_en), .par_val(a_par_val),
    .pad_en(a_pad_en), .pad_val(a_pad_val),
    .kind(a_kind), .pad_idx(a_idx)
  );

  mpo_decode #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .ADDR_W(ADDR_W),
               .PAR_BASE(PAR_BASE), .PAD_BASE(PAD_BASE)) u_dec_b (
    .addr(b_addr), .we(b_we), .wdata(b_wdata),
    .par_en(b_par_en), .par_val(b_par_val),
    .pad_en(b_pad_en), .pad_val(b_pad_val),
    .kind(b_kind), .pad_idx(b_idx)
  );

  mpo_store #(.NPADS(NPADS)) u_store (
    .clk(clk), .rst(rst),
    .a_par_en(a_par_en), .a_par_val(a_par_val),
    .a_pad_en(a_pad_en), .a_pad_val(a_pad_val),
    .b_par_en(b_par_en), .b_par_val(b_par_val),
    .b_pad_en(b_pad_en), .b_pad_val(b_pad_val),
    .q(q)
  );

  mpo_rdport #(.NPADS(NPADS), .BUS_W(BUS_W)) u_rd_a (
    .clk(clk), .rst(rst), .kind(a_kind), .pad_idx(a_idx), .q(q), .rdata(a_rdata)
  );

  mpo_rdport #(.NPADS(NPADS), .BUS_W(BUS_W)) u_rd_b (
    .clk(clk), .rst(rst), .kind(b_kind), .pad_idx(b_idx), .q(q), .rdata(b_rdata)
  );

  assign pad_out = q;
endmodule

// File: rtl/mpo_chk.sv
module mpo_chk #(
  parameter int unsigned NUM_PORTS = 12,
  parameter int unsigned PORT_W    = 16,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned PAR_BASE  = 0,
  parameter int unsigned PAD_BASE  = 256,
  localparam int unsigned NPADS    = NUM_PORTS * PORT_W,
  localparam int unsigned BUS_W    = 2 * PORT_W
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] a_addr,
  input logic              a_we,
  input logic [BUS_W-1:0]  a_wdata,
  input logic [BUS_W-1:0]  a_rdata,
  input logic              b_we,
  input logic [NPADS-1:0]  pad_out
);
  int unsigned a_u;
  logic a_is_pad, a_is_par, a_is_oor;
  int unsigned a_n;

  assign a_u      = int'(a_addr);
  assign a_is_pad = (a_u >= PAD_BASE) && (a_u < PAD_BASE + NPADS);
  assign a_is_par = (a_u >= PAR_BASE) && (a_u < PAR_BASE + 4 * NUM_PORTS) && (a_u % 4 == 0);
  assign a_is_oor = !a_is_pad && !a_is_par;
  assign a_n      = a_is_pad ? (a_u - PAD_BASE) : 0;

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pad_out == '0));

  // R2
  zero_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (a_we && a_is_par && a_wdata[BUS_W-1:PORT_W] == '0 && !b_we) |=> $stable(pad_out));

  // R9
  ignored_write_chk: assert property (@(posedge clk) disable iff (rst)
    (a_we && a_is_oor && !b_we) |=> $stable(pad_out));

  // R5
  pad_write_chk: assert property (@(posedge clk) disable iff (rst)
    (a_we && a_is_pad && !b_we) |=> (pad_out[$past(a_n)] == $past(a_wdata[0])));

  // R4
  zero_read_chk: assert property (@(posedge clk) disable iff (rst)
    !a_is_pad |=> (a_rdata == '0));

  // R5
  narrow_read_chk: assert property (@(posedge clk) disable iff (rst)
    a_rdata[BUS_W-1:1] == '0);
endmodule

bind gpio_mpo_bank mpo_chk #(
  .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .ADDR_W(ADDR_W),
  .PAR_BASE(PAR_BASE), .PAD_BASE(PAD_BASE)
) u_chk (
  .clk(clk), .rst(rst), .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata),
  .a_rdata(a_rdata), .b_we(b_we), .pad_out(pad_out)
);

// File: tb/sim_gpio_mpo_bank.sv
`timescale 1ns/1ps
module sim_gpio_mpo_bank;
  localparam int NP   = 12;
  localparam int PW   = 16;
  localparam int AW   = 12;
  localparam int NPAD = NP * PW;
  localparam int PARB = 0;
  localparam int PADB = 256;

  logic            clk = 0;
  logic            rst = 1;
  logic [AW-1:0]   a_addr = '0, b_addr = '0;
  logic            a_we = 0, b_we = 0;
  logic [31:0]     a_wdata = '0, b_wdata = '0;
  logic [31:0]     a_rdata, b_rdata;
  logic [NPAD-1:0] pad_out;

  logic [NPAD-1:0] model = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_mpo_bank u0 (
    .clk(clk), .rst(rst),
    .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_addr(b_addr), .b_we(b_we), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .pad_out(pad_out)
  );

  function automatic bit is_par(input logic [AW-1:0] ad);
    int u = int'(ad);
    return (u >= PARB) && (u < PARB + 4 * NP) && (u % 4 == 0);
  endfunction

  function automatic bit is_pad(input logic [AW-1:0] ad);
    int u = int'(ad);
    return (u >= PADB) && (u < PADB + NPAD);
  endfunction

  function automatic logic [NPAD-1:0] put_par(input logic [NPAD-1:0] m,
      input logic [AW-1:0] ad, input logic [31:0] wd);
    int x = (int'(ad) - PARB) / 4;
    for (int y = 0; y < PW; y++)
      if (wd[31-y]) m[x*PW+y] = wd[15-y];
    return m;
  endfunction

  function automatic logic [NPAD-1:0] next_model(input logic [NPAD-1:0] m,
      input logic [AW-1:0] aa, input logic aw, input logic [31:0] ad,
      input logic [AW-1:0] ba, input logic bw, input logic [31:0] bd);
    // lowest priority first: B pad, A pad, B port, A port
    if (bw && is_pad(ba)) m[int'(ba) - PADB] = bd[0];
    if (aw && is_pad(aa)) m[int'(aa) - PADB] = ad[0];
    if (bw && is_par(ba)) m = put_par(m, ba, bd);
    if (aw && is_par(aa)) m = put_par(m, aa, ad);
    return m;
  endfunction

  function automatic logic [31:0] read_exp(input logic [NPAD-1:0] m, input logic [AW-1:0] ad);
    if (is_pad(ad)) return {31'b0, m[int'(ad) - PADB]};
    return 32'b0;
  endfunction

  task automatic chk(input string tag, input logic [NPAD-1:0] act, input logic [NPAD-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one cycle on both ports, then check pads and read data
  task automatic cyc(input string tag,
      input logic [AW-1:0] aa, input logic aw, input logic [31:0] ad,
      input logic [AW-1:0] ba, input logic bw, input logic [31:0] bd);
    logic [31:0] ea, eb;
    a_addr = aa; a_we = aw; a_wdata = ad;
    b_addr = ba; b_we = bw; b_wdata = bd;
    ea = read_exp(model, aa);
    eb = read_exp(model, ba);
    model = next_model(model, aa, aw, ad, ba, bw, bd);
    @(negedge clk);
    chk(tag, pad_out, model);
    chk(is_pad(aa) ? "R5 read A" : "R4/R9 read A", NPAD'(a_rdata), NPAD'(ea));
    chk(is_pad(ba) ? "R10 read B" : "R10 zero read B", NPAD'(b_rdata), NPAD'(eb));
    a_we = 0; b_we = 0;
  endtask

  function automatic logic [AW-1:0] rnd_addr();
    int k = $urandom_range(0, 9);
    if (k < 4) return AW'(PARB + 4 * $urandom_range(0, NP - 1));
    if (k < 8) return AW'(PADB + $urandom_range(0, NPAD - 1));
    if (k == 8) return AW'(PADB + NPAD + $urandom_range(0, 40));
    return AW'($urandom_range(0, 4095));
  endfunction

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1 reset pads", pad_out, '0);
    chk("R1 reset rdata", NPAD'(a_rdata | b_rdata), '0);

    // R3: edge pins of first and last port
    cyc("R3 msb to pin 0", 12'h000, 1, 32'hFFFF_8000, 0, 0, 0);
    chk("R3 pin 0 set", NPAD'(pad_out[0]), NPAD'(1));
    cyc("R3 lsb to pin 191", 12'h02C, 1, 32'hFFFF_0001, 0, 0, 0);
    chk("R3 pin 191 set", NPAD'(pad_out[191]), NPAD'(1));
    chk("R3 pin 176 clear", NPAD'(pad_out[176]), NPAD'(0));
    // R2: partial mask on port 3 touches pads 56..63 only
    cyc("R2 partial mask", 12'h00C, 1, 32'h00FF_FFFF, 0, 0, 0);
    chk("R2 pads 56..63", NPAD'(pad_out[63:48]), NPAD'(16'hFF00));
    cyc("R2 zero mask", 12'h00C, 1, 32'h0000_0000, 0, 0, 0);

    // R6: coherence both directions
    cyc("R6 pad write", 12'h100 + 12'd21, 1, 32'hFFFF_FFFF, 0, 0, 0);
    cyc("R6 pad read back", 12'h100 + 12'd21, 0, 0, 0, 0, 0);
    cyc("R6 port write", 12'h004, 1, 32'h0400_0000, 0, 0, 0);
    cyc("R6 pad view of port write", 12'h100 + 12'd21, 0, 0, 0, 0, 0);

    // R7: port write beats pad write in either direction
    cyc("R7 pad A vs port B", 12'h100 + 12'd20, 1, 32'h1, 12'h004, 1, 32'h0800_0000);
    chk("R7 pad 20 cleared", NPAD'(pad_out[20]), NPAD'(0));
    cyc("R7 port A vs pad B", 12'h004, 1, 32'h0800_0800, 12'h100 + 12'd20, 1, 32'h0);
    chk("R7 pad 20 set", NPAD'(pad_out[20]), NPAD'(1));

    // R8: same kind, A wins
    cyc("R8 pad vs pad", 12'h100 + 12'd99, 1, 32'h1, 12'h100 + 12'd99, 1, 32'h0);
    chk("R8 pad 99 from A", NPAD'(pad_out[99]), NPAD'(1));
    cyc("R8 port vs port", 12'h018, 1, 32'hFFFF_0000, 12'h018, 1, 32'hFFFF_FFFF);
    chk("R8 port 6 from A", NPAD'(pad_out[111:96]), NPAD'(0));

    // R9: ignored addresses
    cyc("R9 past port range", 12'h030, 1, 32'hFFFF_FFFF, 0, 0, 0);
    cyc("R9 misaligned", 12'h001, 1, 32'hFFFF_FFFF, 0, 0, 0);
    cyc("R9 past pad range", 12'h1C0, 1, 32'hFFFF_FFFF, 12'hFFF, 1, 32'hFFFF_FFFF);

    // R10 and mixed random traffic on both ports
    for (int i = 0; i < 600; i++) begin
      logic [AW-1:0] ra, rb;
      ra = rnd_addr();
      rb = ($urandom_range(0, 3) == 0) ? ra : rnd_addr();
      cyc("R2/R7/R10 random", ra, 1'($urandom_range(0, 1)), $urandom(),
          rb, 1'($urandom_range(0, 1)), $urandom());
    end
    // R3: edge pins of every port through port B
    for (int x = 0; x < NP; x++) begin
      cyc("R3 port B edges", 12'h000, 0, 0, AW'(PARB + 4 * x), 1, 32'h8001_8000);
      chk("R3 low edge", NPAD'(pad_out[x*PW]), NPAD'(1));
      chk("R3 high edge", NPAD'(pad_out[x*PW+15]), NPAD'(0));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule